// File: doc/BRIEF.md
# Composite Sync Field Decoder

This block watches a composite sync line that has already been captured into the pixel clock domain. It takes one sample per pixel strobe. From the spacing of the active sync edges it learns the length of a line in pixels. It picks out the vertical-interval pulses that arrive half a line apart. At the end of each vertical interval it recovers the field parity and decides whether the source is interlaced.

The line counter and the destination row it produces let a downstream writer weave fields into a frame buffer of twice the field height. In an interlaced stream, even fields go to even rows and odd fields to odd rows. The other rows keep the previous field, so the woven picture is refreshed on every field. In a progressive stream, rows follow the line count directly.

The strobe passed downstream is held off for a programmable number of pixels after each active edge. This hides glitches at the line boundary. A small configuration register chooses which edge of the sync pulse is the line reference and sets the hold-off length.

Top module: `csync_field_decoder`

## Requirements
- R1: After reset, line_len, line_idx, dst_row, field_par, interlaced, field_start and pix_out are all 0, the trailing edge is the active reference, and the hold-off length is 2.
- R2: The sync input csync_n is active low. With cfg_trail=1 the active edge is the pixel where csync_n goes from 0 to 1 (end of the pulse). With cfg_trail=0 it is the pixel where csync_n goes from 1 to 0. The previous sample resets to 1.
- R3: The interval of an active edge is the number of pixel strobes from the previous active edge to this one, or from reset for the first edge. The count saturates at 2^CNT_W-1. Every edge that is not a half-line edge loads its interval into line_len, visible one clock later.
- R4: An edge is a half-line edge when line_len is nonzero and its interval differs from floor(line_len/2) by at most TOL. A half-line edge leaves line_len and line_idx unchanged.
- R5: line_idx is set to 0 at a field boundary. It rises by 1 on every other whole-line edge and saturates at 2^LINE_W-1.
- R6: A field boundary is a whole-line edge that ends a run of one or more half-line edges. field_start pulses high for exactly the clock after it, and field_par takes bit 0 of the number of half-line edges in the run.
- R7: At each field boundary, interlaced becomes 1 if the new parity differs from the previous field's parity and 0 if it matches. The previous parity resets to 0. Both flags change only at field boundaries.
- R8: dst_row equals 2*line_idx+field_par while interlaced is 1, and equals line_idx while it is 0.
- R9: pix_out is high on a pixel strobe at an active edge. It is low on the next G pixel strobes that are not themselves active edges, where G is the hold-off length, and high on all other strobes. G=0 suppresses nothing.
- R10: When cfg_we is high at a clock edge, cfg_trail and cfg_gate (0 to 7) are loaded and apply from the next pixel strobe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | One-cycle pixel strobe; csync_n is sampled on it |
| csync_n | input | 1 | Composite sync, active low |
| cfg_we | input | 1 | Configuration load enable |
| cfg_trail | input | 1 | 1 = trailing edge is the active reference, 0 = leading edge |
| cfg_gate | input | 3 | Hold-off length in pixels after the active edge |
| pix_out | output | 1 | Gated pixel strobe for downstream capture |
| line_len | output | CNT_W | Measured line length in pixels |
| line_idx | output | LINE_W | Line index within the current field |
| dst_row | output | LINE_W+1 | Destination row in the double-height buffer |
| field_par | output | 1 | Parity of the current field |
| interlaced | output | 1 | Interlaced source detected |
| field_start | output | 1 | One-clock pulse after a field boundary |

## Verification
The bench builds the block with CNT_W=8, LINE_W=5 and TOL=1. With these values a 36-line field drives the line index into its ceiling, and every run length and half-line tolerance case stays a few dozen pixels long. It sweeps every hold-off length from 0 to 7 in both edge modes. It plays progressive fields, fields that alternate between odd and even runs of half-line pulses, and a return to progressive, and checks the gated strobe on every pixel against an arithmetic model.

// File: rtl/csfd_pkg.sv
package csfd_pkg;

  // Half-line classification: interval near half the learned line length
  function automatic logic is_half_fn(input int iv, input int len, input int tol);
    int h;
    int d;
    h = len / 2;
    d = (iv > h) ? iv - h : h - iv;
    return (len != 0) && (d <= tol);
  endfunction

  // Destination row in a double-height weave buffer
  function automatic int row_fn(input int line, input logic par, input logic il);
    return il ? (2 * line + int'(par)) : line;
  endfunction

endpackage

// File: rtl/csfd_edge.sv
module csfd_edge #(
  parameter int GATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              csync_n,
  input  logic              trail,
  input  logic [GATE_W-1:0] gate_len,
  output logic              edge_now,
  output logic              pix_out
);
  logic              prev_s;
  logic [GATE_W-1:0] gcnt;

  always_comb begin
    if (trail) edge_now = pix_en && !prev_s && csync_n;
    else       edge_now = pix_en && prev_s && !csync_n;
    pix_out = pix_en && (edge_now || (gcnt == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= 1'b1;
      gcnt   <= '0;
    end else if (pix_en) begin
      prev_s <= csync_n;
      if (edge_now)          gcnt <= gate_len;
      else if (gcnt != '0)   gcnt <= gcnt - 1'b1;
    end
  end
endmodule

// File: rtl/csfd_meter.sv
module csfd_meter
  import csfd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             edge_now,
  output logic [CNT_W-1:0] line_len,
  output logic             half_evt,
  output logic             full_evt
);
  logic [CNT_W-1:0] cnt;
  logic             half_iv;

  always_comb begin
    half_iv  = is_half_fn(32'(cnt), 32'(line_len), TOL);
    half_evt = edge_now && half_iv;
    full_evt = edge_now && !half_iv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      line_len <= '0;
    end else begin
      if (edge_now)                   cnt <= CNT_W'(1);
      else if (pix_en && cnt != '1)   cnt <= cnt + 1'b1;
      if (full_evt) line_len <= cnt;
    end
  end
endmodule

// File: rtl/csfd_field.sv
module csfd_field
  import csfd_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int RUN_W  = 5,
  localparam int ROW_W = LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_evt,
  input  logic              full_evt,
  output logic [LINE_W-1:0] line_idx,
  output logic [ROW_W-1:0]  dst_row,
  output logic              field_par,
  output logic              interlaced,
  output logic              field_start,
  output logic              fld_evt
);
  logic             in_run;
  logic [RUN_W-1:0] run_cnt;

  always_comb begin
    fld_evt = full_evt && in_run;
    dst_row = ROW_W'(row_fn(32'(line_idx), field_par, interlaced));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run      <= 1'b0;
      run_cnt     <= '0;
      line_idx    <= '0;
      field_par   <= 1'b0;
      interlaced  <= 1'b0;
      field_start <= 1'b0;
    end else begin
      field_start <= fld_evt;
      if (half_evt) begin
        in_run  <= 1'b1;
        run_cnt <= run_cnt + 1'b1;
      end else if (fld_evt) begin
        in_run     <= 1'b0;
        run_cnt    <= '0;
        field_par  <= run_cnt[0];
        interlaced <= run_cnt[0] ^ field_par;
        line_idx   <= '0;
      end else if (full_evt && line_idx != '1) begin
        line_idx <= line_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csync_field_decoder.sv
module csync_field_decoder #(
  parameter int CNT_W  = 11,
  parameter int LINE_W = 9,
  parameter int TOL    = 2,
  parameter int RUN_W  = 5,
  localparam int GATE_W = 3,
  localparam int ROW_W  = LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              csync_n,
  input  logic              cfg_we,
  input  logic              cfg_trail,
  input  logic [GATE_W-1:0] cfg_gate,
  output logic              pix_out,
  output logic [CNT_W-1:0]  line_len,
  output logic [LINE_W-1:0] line_idx,
  output logic [ROW_W-1:0]  dst_row,
  output logic              field_par,
  output logic              interlaced,
  output logic              field_start
);
  logic              trail_q;
  logic [GATE_W-1:0] gate_q;
  logic              edge_now;
  logic              half_evt;
  logic              full_evt;
  logic              fld_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trail_q <= 1'b1;
      gate_q  <= GATE_W'(2);
    end else if (cfg_we) begin
      trail_q <= cfg_trail;
      gate_q  <= cfg_gate;
    end
  end

  csfd_edge #(.GATE_W(GATE_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .csync_n(csync_n),
    .trail(trail_q), .gate_len(gate_q), .edge_now(edge_now), .pix_out(pix_out)
  );

  csfd_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .edge_now(edge_now),
    .line_len(line_len), .half_evt(half_evt), .full_evt(full_evt)
  );

  csfd_field #(.LINE_W(LINE_W), .RUN_W(RUN_W)) u_field (
    .clk(clk), .rst_n(rst_n), .half_evt(half_evt), .full_evt(full_evt),
    .line_idx(line_idx), .dst_row(dst_row), .field_par(field_par),
    .interlaced(interlaced), .field_start(field_start), .fld_evt(fld_evt)
  );

  // R3: line length moves only on an active edge
  p_len_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_now |=> $stable(line_len));
  // R4: a half-line edge keeps the learned length
  p_half_keeps_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |=> $stable(line_len));
  // R5: a new field starts at line zero
  p_field_line_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> line_idx == '0);
  // R6: boundary pulse lasts one clock
  p_fs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);
  // R7: flags move only at field boundaries
  p_il_at_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_evt |=> ($stable(interlaced) && $stable(field_par)));
  // R8: woven row parity follows field parity
  p_row_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    interlaced |-> dst_row[0] == field_par);
  // R9: the strobe at the active edge itself always passes
  p_strobe_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> pix_out);
endmodule

// File: tb/sim_csync_field_decoder.sv
module sim_csync_field_decoder;
  localparam int CNT_W  = 8;
  localparam int LINE_W = 5;
  localparam int TOL    = 1;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int LMAX   = (1 << LINE_W) - 1;

  logic clk = 1'b0;
  logic rst_n, pix_en, csync_n, cfg_we, cfg_trail;
  logic [2:0] cfg_gate;
  logic pix_out, field_par, interlaced, field_start;
  logic [CNT_W-1:0] line_len;
  logic [LINE_W-1:0] line_idx;
  logic [LINE_W:0] dst_row;

  always #2 clk = ~clk;

  csync_field_decoder #(.CNT_W(CNT_W), .LINE_W(LINE_W), .TOL(TOL)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .csync_n(csync_n),
    .cfg_we(cfg_we), .cfg_trail(cfg_trail), .cfg_gate(cfg_gate),
    .pix_out(pix_out), .line_len(line_len), .line_idx(line_idx),
    .dst_row(dst_row), .field_par(field_par), .interlaced(interlaced),
    .field_start(field_start)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_trail = 1, m_gate = 2, m_prev = 1, m_cnt = 0, m_g = 0;
  int m_len = 0, m_line = 0, m_par = 0, m_il = 0, m_run = 0, m_runc = 0, m_fs = 0;
  string m_tag = "R2/R9";

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_model(input int iv);
    int h, d, np;
    h = m_len / 2;
    d = (iv > h) ? iv - h : h - iv;
    if (m_len != 0 && d <= TOL) begin
      m_run = 1; m_runc++;
    end else begin
      m_len = (iv > CMAX) ? CMAX : iv;
      if (m_run != 0) begin
        np = m_runc % 2;
        m_il = (np != m_par) ? 1 : 0;
        m_par = np; m_line = 0; m_run = 0; m_runc = 0; m_fs = 1;
      end else if (m_line < LMAX) m_line++;
    end
  endtask

  task automatic px(input logic s);
    int e;
    @(negedge clk); csync_n = s; pix_en = 1'b1; #1;
    e = (m_trail != 0) ? (m_prev == 0 && s == 1'b1) : (m_prev == 1 && s == 1'b0);
    chk(m_tag, int'(pix_out), (e != 0 || m_g == 0) ? 1 : 0);
    m_fs = 0;
    if (e != 0) begin
      edge_model(m_cnt); m_cnt = 1; m_g = m_gate;
    end else begin
      if (m_cnt < CMAX) m_cnt++;
      if (m_g > 0) m_g--;
    end
    m_prev = int'(s);
    @(posedge clk); #1; pix_en = 1'b0;
    chk("R6", int'(field_start), m_fs);
  endtask

  task automatic state_chk();
    chk("R3/R4", int'(line_len), m_len);
    chk("R5", int'(line_idx), m_line);
    chk("R6", int'(field_par), m_par);
    chk("R7", int'(interlaced), m_il);
    chk("R8", int'(dst_row), (m_il != 0) ? 2 * m_line + m_par : m_line);
  endtask

  task automatic pulse(input int sp);
    for (int i = 0; i < sp; i++) px((i < 3) ? 1'b0 : 1'b1);
    state_chk();
  endtask

  task automatic field(input int nl, input int nh);
    for (int i = 0; i < nl; i++) pulse(40);
    for (int i = 0; i < nh; i++) pulse(20);
  endtask

  task automatic cfg(input int tr, input int g);
    @(negedge clk); cfg_we = 1'b1; cfg_trail = tr[0]; cfg_gate = g[2:0];
    @(posedge clk); #1; cfg_we = 1'b0;
    m_trail = tr; m_gate = g;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; csync_n = 1'b1; cfg_we = 1'b0;
    cfg_trail = 1'b0; cfg_gate = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(line_len), 0);
    chk("R1", int'(line_idx), 0);
    chk("R1", int'(dst_row), 0);
    chk("R1", int'(field_par), 0);
    chk("R1", int'(interlaced), 0);
    chk("R1", int'(field_start), 0);
    chk("R1", int'(pix_out), 0);
    // R1 / R10 defaults: trailing edge, hold-off 2 (checked per pixel by model)
    field(3, 0);
    field(8, 6); field(8, 6);          // progressive
    field(8, 5); field(8, 6);          // interlaced, alternating parity
    field(8, 5); field(8, 6);
    field(8, 6); field(8, 6);          // back to progressive
    field(36, 5); field(4, 6);         // line index saturation
    m_tag = "R2/R9/R10";
    for (int g = 0; g < 8; g++) begin
      cfg(0, g); field(3, 0);
      cfg(1, g); field(3, 0);
    end
    cfg(0, 2);
    field(6, 5); field(6, 6); field(6, 5); field(6, 5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule